// File: doc/BRIEF.md
# Bit-serial two-symbol ANS decoder

This block recovers a sequence of binary symbols from a bit-serial payload produced by an asymmetric-numeral-system coder with a fixed model. Symbol `a` has probability 1/4 and symbol `b` has probability 3/4. The coder state lives in a 5-bit register and is kept inside the window 16..31 between symbols. The encoder sends its final state ahead of the payload. The consumer loads that value through the initial-state port and then requests symbols one at a time.

For each request the block inverts the coding function in a single step. If the state is a multiple of 4, the symbol is `a` and the state is divided by 4. Otherwise the symbol is `b` and the state becomes 3·floor(x/4) + (x mod 4) − 1. While the state is below 16, the block pulls one payload bit per accepted beat and forms 2·x + bit. Once the state is back in the window it presents the symbol. Bits are only requested when the state is below the window, so the decoder stays in step with the encoder and consumes exactly the bits that the encoder wrote at that point.

The controller has four named states:
- EMPTY: after reset, no state loaded.
- IDLE: a state is loaded and the block waits for a request.
- FILL: the state is below 16 and bits are being pulled in.
- OUT: a symbol is being presented.

It has these transitions:
- load: EMPTY or IDLE to IDLE.
- decode: IDLE to FILL, or IDLE straight to OUT when no refill is needed.
- refill-done: FILL to OUT.
- handoff: OUT to IDLE.

Top module: `ans_bin_decoder`

## Requirements
- R1: A synchronous active-high reset puts the block in EMPTY. After reset, `req_ready`, `bit_ready` and `sym_valid` are all 0.
- R2: A load (`init_valid`=1) is accepted in EMPTY or IDLE, unless a request is accepted in the same cycle. `req_ready` is 1 on the next cycle. A load value below 16 (bit 4 = 0) is ignored, and the block stays in its state.
- R3: While the block is EMPTY, a request is held off. `req_ready` stays 0, and neither `bit_ready` nor `sym_valid` rises.
- R4: When the state is divisible by 4, the decoded symbol is `a`, given as `sym_out`=0, and the new state is x/4.
- R5: Otherwise the decoded symbol is `b`, given as `sym_out`=1, and the new state is 3·floor(x/4) + (x mod 4) − 1.
- R6: While the state is below 16, `bit_ready` is 1. Each accepted bit makes the state 2·x + `bit_data`. Refill stops as soon as the state reaches 16 or more.
- R7: When the decoded state is already 16 or more, no bit is read. `bit_ready` stays 0 and the symbol is presented on the next cycle.
- R8: `sym_valid` rises only after refill has finished. It holds with a stable `sym_out` until `sym_ready` is 1.
- R9: From a loaded state of 19 with payload bits 0,1,0,0,0, five requests yield b,a,b,b,a. They read 1,2,0,0,2 bits in that order, and the final state is 16.
- R10: While `bit_ready` is 1 and `bit_valid` is 0, the state holds and no symbol is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_valid | input | 1 | Load strobe for the starting state |
| init_state | input | 5 | Starting state sent ahead of the payload |
| req_valid | input | 1 | Request to decode one symbol |
| req_ready | output | 1 | Request accepted (IDLE) |
| bit_valid | input | 1 | Payload bit present |
| bit_data | input | 1 | Payload bit value |
| bit_ready | output | 1 | Block wants a payload bit (FILL) |
| sym_valid | output | 1 | Decoded symbol present (OUT) |
| sym_out | output | 1 | Decoded symbol, 0 = a, 1 = b |
| sym_ready | input | 1 | Consumer takes the symbol |

## Verification
The bench loads every starting state from 16 to 31 and checks three things for each: the symbol, the number of bits pulled, and the symbol that follows. This catches a wrong branch of the inverse map, an off-by-one in the `b` formula, or a refill that stops one bit early or late. A design that asked for a bit when the decoded state was already in range would show up on starting states 22, 23, 25..27 and 29..31, and would drift out of step with the payload. Further directed tests cover four more cases. Out-of-window loads must be dropped rather than accepted. A request while EMPTY must not start a decode from a zero state. A stalled bit source must not corrupt the state. A held-back consumer must not lose or change the symbol.

// File: rtl/ans_dec_pkg.sv
package ans_dec_pkg;
    localparam int STATE_W = 5;
    localparam int LOW_BOUND = 1 << (STATE_W - 1);

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FILL  = 2'd2,
        ST_OUT   = 2'd3
    } dec_st_t;

    localparam logic SYM_A = 1'b0;
    localparam logic SYM_B = 1'b1;

    function automatic logic in_window(input logic [STATE_W-1:0] x);
        return x >= STATE_W'(LOW_BOUND);
    endfunction
endpackage

// File: rtl/ans_inverse_map.sv
module ans_inverse_map
    import ans_dec_pkg::*;
(
    input  logic [STATE_W-1:0] x_in,
    output logic               sym,
    output logic [STATE_W-1:0] x_out
);
    logic [STATE_W-1:0] quot;
    logic [STATE_W-1:0] rem;

    always_comb begin
        quot = STATE_W'(x_in[STATE_W-1:2]);
        rem  = STATE_W'(x_in[1:0]);
        if (rem == '0) begin
            sym   = SYM_A;
            x_out = quot;
        end else begin
            sym   = SYM_B;
            x_out = (quot << 1) + quot + rem - STATE_W'(1);
        end
    end
endmodule

// File: rtl/ans_refill.sv
module ans_refill
    import ans_dec_pkg::*;
(
    input  logic [STATE_W-1:0] x_in,
    input  logic               bit_in,
    output logic [STATE_W-1:0] x_out,
    output logic               done
);
    always_comb begin
        x_out = {x_in[STATE_W-2:0], bit_in};
        done  = in_window(x_out);
    end
endmodule

// File: rtl/ans_bin_decoder.sv
module ans_bin_decoder
    import ans_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               init_valid,
    input  logic [STATE_W-1:0] init_state,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               bit_valid,
    input  logic               bit_data,
    output logic               bit_ready,
    output logic               sym_valid,
    output logic               sym_out,
    input  logic               sym_ready
);
    dec_st_t            st_q, st_d;
    logic [STATE_W-1:0] x_q, x_d;
    logic               sym_q, sym_d;

    logic               dec_sym;
    logic [STATE_W-1:0] dec_x;
    logic [STATE_W-1:0] fill_x;
    logic               fill_done;

    ans_inverse_map u_map (
        .x_in  (x_q),
        .sym   (dec_sym),
        .x_out (dec_x)
    );

    ans_refill u_fill (
        .x_in   (x_q),
        .bit_in (bit_data),
        .x_out  (fill_x),
        .done   (fill_done)
    );

    // next-state logic
    always_comb begin
        st_d  = st_q;
        x_d   = x_q;
        sym_d = sym_q;
        unique case (st_q)
            ST_EMPTY: begin
                if (init_valid && in_window(init_state)) begin
                    x_d  = init_state;
                    st_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    x_d   = dec_x;
                    sym_d = dec_sym;
                    st_d  = in_window(dec_x) ? ST_OUT : ST_FILL;
                end else if (init_valid && in_window(init_state)) begin
                    x_d = init_state;
                end
            end
            ST_FILL: begin
                if (bit_valid) begin
                    x_d = fill_x;
                    if (fill_done) st_d = ST_OUT;
                end
            end
            ST_OUT: begin
                if (sym_ready) st_d = ST_IDLE;
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_EMPTY;
            x_q   <= '0;
            sym_q <= SYM_A;
        end else begin
            st_q  <= st_d;
            x_q   <= x_d;
            sym_q <= sym_d;
        end
    end

    // outputs
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        bit_ready = (st_q == ST_FILL);
        sym_valid = (st_q == ST_OUT);
        sym_out   = sym_q;
    end

    // R3: no request is taken without a loaded state
    assert_empty_holdoff_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EMPTY) |-> !req_ready && !bit_ready && !sym_valid);

    // R6: bits are requested only below the window
    assert_fill_below_R6: assert property (@(posedge clk) disable iff (rst)
        bit_ready |-> !in_window(x_q));

    // R7: an in-window decode goes straight to the output
    assert_no_read_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && in_window(dec_x)) |=> sym_valid && !bit_ready);

    // R8: a presented symbol comes with an in-window state
    assert_out_in_window_R8: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> in_window(x_q));

    // R8: the symbol holds until taken
    assert_sym_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !sym_ready) |=> sym_valid && $stable(sym_out));

    // R10: a stalled bit source freezes the state
    assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (bit_ready && !bit_valid) |=> bit_ready && $stable(x_q));
endmodule

// File: tb/ans_bin_decoder_test.sv
module ans_bin_decoder_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       init_valid = 1'b0;
    logic [4:0] init_state = '0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic       bit_ready;
    logic       sym_valid;
    logic       sym_out;
    logic       sym_ready = 1'b0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ans_bin_decoder uut (
        .clk(clk), .rst(rst), .init_valid(init_valid), .init_state(init_state),
        .req_valid(req_valid), .req_ready(req_ready), .bit_valid(bit_valid),
        .bit_data(bit_data), .bit_ready(bit_ready), .sym_valid(sym_valid),
        .sym_out(sym_out), .sym_ready(sym_ready)
    );

    // per starting state 16..31: {symbol, bits read when all payload bits are 0}
    localparam logic [2:0] VEC [0:15] = '{
        3'b0_10, 3'b1_01, 3'b1_01, 3'b1_01,
        3'b0_10, 3'b1_01, 3'b1_00, 3'b1_00,
        3'b0_10, 3'b1_00, 3'b1_00, 3'b1_00,
        3'b0_10, 3'b1_00, 3'b1_00, 3'b1_00
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_next(input int x);
        if (x % 4 == 0) return x / 4;
        return 3 * (x / 4) + (x % 4) - 1;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_load(input logic [4:0] v);
        @(negedge clk);
        init_valid = 1'b1;
        init_state = v;
        @(negedge clk);
        init_valid = 1'b0;
    endtask

    task automatic do_decode(input logic [7:0] bits, output logic s, output int n);
        int guard = 0;
        n = 0;
        @(negedge clk);
        req_valid = 1'b1;
        while (!req_ready && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (!sym_valid && guard < 40) begin
            guard++;
            if (bit_ready) begin
                bit_valid = 1'b1;
                bit_data  = bits[n];
                n++;
                @(negedge clk);
                bit_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        s = sym_out;
        sym_ready = 1'b1;
        @(negedge clk);
        sym_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic s;
        int   n;
        do_reset();
        // R1 reset state
        check(!req_ready && !bit_ready && !sym_valid, "R1 reset outputs",
              {req_ready, bit_ready, sym_valid}, 0);

        // R3 request held off while EMPTY
        req_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!req_ready && !bit_ready && !sym_valid, "R3 holdoff",
                  {req_ready, bit_ready, sym_valid}, 0);
        end
        req_valid = 1'b0;

        // R2 out-of-window loads ignored, in-window load accepted
        do_load(5'd9);
        check(!req_ready, "R2 load 9 ignored", req_ready, 0);
        do_load(5'd0);
        check(!req_ready, "R2 load 0 ignored", req_ready, 0);
        do_load(5'd20);
        check(req_ready, "R2 load 20 accepted", req_ready, 1);
        do_load(5'd3);
        do_decode(8'h00, s, n);
        check(s == 1'b0, "R2 ignored reload keeps state 20", s, 0);

        // table walk: R4/R5 symbol, R6/R7 bit count, next symbol via model
        for (int i = 0; i < 16; i++) begin
            int y;
            do_reset();
            do_load(5'(16 + i));
            do_decode(8'h00, s, n);
            check(s == VEC[i][2], VEC[i][2] ? "R5 symbol b" : "R4 symbol a", s, VEC[i][2]);
            check(n == int'(VEC[i][1:0]), (VEC[i][1:0] == 0) ? "R7 bits read" : "R6 bits read",
                  n, VEC[i][1:0]);
            y = model_next(16 + i);
            while (y < 16) y = 2 * y;
            do_decode(8'hFF, s, n);
            check(s == logic'(y % 4 != 0), (y % 4 != 0) ? "R5 follow-on" : "R4 follow-on",
                  s, (y % 4 != 0));
        end

        // R9 worked sequence
        begin
            logic [7:0] pat [5] = '{8'h00, 8'h01, 8'h00, 8'h00, 8'h00};
            logic       es  [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
            int         en  [5] = '{1, 2, 0, 0, 2};
            do_reset();
            do_load(5'd19);
            for (int k = 0; k < 5; k++) begin
                do_decode(pat[k], s, n);
                check(s == es[k], "R9 symbol", s, es[k]);
                check(n == en[k], "R9 bits", n, en[k]);
            end
            do_decode(8'h00, s, n);
            check(s == 1'b0 && n == 2, "R9 final state 16", n, 2);
        end

        // R10 stalled bit source
        do_reset();
        do_load(5'd16);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(bit_ready && !sym_valid, "R10 stall", {bit_ready, sym_valid}, 2);
            @(negedge clk);
        end
        bit_valid = 1'b1;
        bit_data  = 1'b0;
        @(negedge clk);
        check(bit_ready && !sym_valid, "R6 one bit not enough", {bit_ready, sym_valid}, 2);
        @(negedge clk);
        bit_valid = 1'b0;
        check(sym_valid && sym_out == 1'b0 && !bit_ready, "R6 refill done", sym_out, 0);
        sym_ready = 1'b1;
        @(negedge clk);
        sym_ready = 1'b0;

        // R8 held symbol, R7 no read
        do_reset();
        do_load(5'd22);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(sym_valid && !bit_ready, "R7 direct output", sym_valid, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(sym_valid && sym_out == 1'b1, "R8 hold", sym_out, 1);
        end
        sym_ready = 1'b1;
        @(negedge clk);
        sym_ready = 1'b0;
        check(!sym_valid && req_ready, "R8 handoff", sym_valid, 0);

        // R1 reset mid-operation
        do_load(5'd25);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!sym_valid && !req_ready && !bit_ready, "R1 mid reset", sym_valid, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule